// File: doc/BRIEF.md
# DAC Register and Update Controller

This block holds the configuration and data registers that sit behind a 10-bit voltage DAC. A two-wire slave front end decodes the bus and hands it single-cycle strobes: a write to this device has begun, a byte has been acknowledged, a START or a STOP has been seen, or a shared sync command has been acknowledged along with its flag bit. From these strobes the block fills a set of input registers. The first byte of a write is the command; the next two bytes are the low and high data.

The block also decides when the input registers move into the output latches that drive the converter. The outputs are the 10-bit code, a power-down flag and a reference-select flag. In the default mode, each STOP moves the input registers to the outputs. When the synchronous-update bit is set, a STOP no longer moves the code. The code then moves only when the shared sync command arrives with its flag high, so several converters on one bus can change together. A sync command with its flag low clears every register, whatever the mode.

Top module: `dac_regctl`

## Requirements
- R1: After reset, `dac_code` is 0, `pwr_down` is 0 and `ref_sel` is 0, and the stored command has all three mode bits at 0.
- R2: The command byte (the first byte after `xfer_begin`) uses bit 0 for synchronous update, bit 1 for power-down and bit 2 for reference select. Bits 7 to 3 have no effect.
- R3: The second byte supplies code bits 7..0. Bits 1..0 of the third byte supply code bits 9..8, and bits 7..2 of the third byte are ignored.
- R4: With synchronous update at 0, a `bus_stop` strobe copies the stored data to `dac_code`, stored bit 1 to `pwr_down` and stored bit 2 to `ref_sel`. The outputs change on the clock edge that samples the strobe and at no earlier edge.
- R5: With synchronous update at 1, `bus_stop` leaves `dac_code` unchanged, but `pwr_down` and `ref_sel` still take the stored command bits.
- R6: With synchronous update at 1, a `sync_stb` with `sync_flag`=1 copies the stored data and command bits to the outputs on the edge that samples it.
- R7: A `sync_stb` with `sync_flag`=1 while synchronous update is 0 changes no output and no stored value.
- R8: A `sync_stb` with `sync_flag`=0 returns all input and output registers to their reset values whatever the mode, so a following STOP also yields zeros.
- R9: Power-down takes effect only at a STOP. The stored code is kept while powered down and is still on `dac_code` when power-down is later cleared.
- R10: A write that ends (by START or STOP) after the command byte but before the third byte updates only the command. The stored data is unchanged.
- R11: `dac_code` changes only on an edge that samples a STOP, a sync command or a clear.
- R12: Bytes after the third byte of a write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_begin | input | 1 | Own-address write acknowledged; next byte is the command |
| byte_stb | input | 1 | A data byte has been acknowledged |
| byte_data | input | 8 | Byte value, valid with `byte_stb` |
| bus_start | input | 1 | START (or repeated START) seen |
| bus_stop | input | 1 | STOP seen |
| sync_stb | input | 1 | Shared sync command acknowledged |
| sync_flag | input | 1 | Flag bit of the sync command: 1 = update, 0 = clear |
| dac_code | output | 10 | Latched converter code |
| pwr_down | output | 1 | Latched power-down flag |
| ref_sel | output | 1 | Latched reference select: 1 = internal, 0 = supply |

## Verification
Every result appears on the first clock edge that samples the causing strobe, because each output is a single register stage fed by that strobe. The bench drives each strobe just after a falling edge, lets one rising edge pass, and compares all three outputs at the next falling edge. A bench model advances in the same step, so each comparison falls exactly one edge after its stimulus. Checks made before a STOP or sync, and after an ignored strobe, confirm that the outputs have not moved too early.

// File: rtl/dac_regctl_pkg.sv
package dac_regctl_pkg;
  localparam int CMD_SY_BIT = 0;
  localparam int CMD_SD_BIT = 1;
  localparam int CMD_BG_BIT = 2;

  typedef struct packed {
    logic bg;
    logic sd;
    logic sy;
  } mode_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CMD,
    SEQ_LO,
    SEQ_HI,
    SEQ_DONE
  } seq_t;
endpackage

// File: rtl/dac_rx_seq.sv
module dac_rx_seq
  import dac_regctl_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              xfer_begin,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              bus_start,
  input  logic              bus_stop,
  output mode_t             in_mode,
  output logic [DATA_W-1:0] in_data
);
  localparam int HI_W = DATA_W - BYTE_W;

  seq_t              seq_q;
  logic [BYTE_W-1:0] lo_stage_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seq_q      <= SEQ_IDLE;
      lo_stage_q <= '0;
      in_mode    <= '0;
      in_data    <= '0;
    end else if (xfer_begin) begin
      seq_q <= SEQ_CMD;
    end else if (bus_start || bus_stop) begin
      seq_q <= SEQ_IDLE;
    end else if (byte_stb) begin
      unique case (seq_q)
        SEQ_CMD: begin
          in_mode.sy <= byte_data[CMD_SY_BIT];
          in_mode.sd <= byte_data[CMD_SD_BIT];
          in_mode.bg <= byte_data[CMD_BG_BIT];
          seq_q      <= SEQ_LO;
        end
        SEQ_LO: begin
          lo_stage_q <= byte_data;
          seq_q      <= SEQ_HI;
        end
        SEQ_HI: begin
          in_data <= {byte_data[HI_W-1:0], lo_stage_q};
          seq_q   <= SEQ_DONE;
        end
        default: seq_q <= seq_q;
      endcase
    end
  end

  assert_abort_keeps_data_R10: assert property (@(posedge clk) disable iff (rst)
    ((bus_start || bus_stop) && !clr) |=> $stable(in_data));

  assert_extra_byte_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (seq_q == SEQ_DONE && byte_stb && !clr && !xfer_begin) |=> ($stable(in_data) && $stable(in_mode)));
endmodule

// File: rtl/dac_upd_ctl.sv
module dac_upd_ctl
  import dac_regctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t in_mode,
  input  logic  bus_stop,
  input  logic  sync_stb,
  input  logic  sync_flag,
  output logic  clr,
  output logic  code_ld,
  output logic  flag_ld
);
  logic sync_upd;

  always_comb begin
    clr      = sync_stb && !sync_flag;
    sync_upd = sync_stb && sync_flag && in_mode.sy;
    code_ld  = !clr && ((bus_stop && !in_mode.sy) || sync_upd);
    flag_ld  = !clr && (bus_stop || sync_upd);
  end

  assert_stop_in_sync_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_stop && in_mode.sy && !sync_stb) |-> (!code_ld && flag_ld));

  assert_sync_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (sync_stb && sync_flag && !in_mode.sy && !bus_stop) |-> (!code_ld && !flag_ld && !clr));

  assert_one_cause_R8: assert property (@(posedge clk) disable iff (rst)
    clr |-> !(code_ld || flag_ld));
endmodule

// File: rtl/dac_out_latch.sv
module dac_out_latch
  import dac_regctl_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              code_ld,
  input  logic              flag_ld,
  input  mode_t             in_mode,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              ref_sel
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dac_code <= '0;
      pwr_down <= 1'b0;
      ref_sel  <= 1'b0;
    end else begin
      if (code_ld) dac_code <= in_data;
      if (flag_ld) begin
        pwr_down <= in_mode.sd;
        ref_sel  <= in_mode.bg;
      end
    end
  end

  assert_code_only_on_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (!code_ld && !clr) |=> $stable(dac_code));

  assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dac_code == '0 && !pwr_down && !ref_sel));

  assert_flags_only_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (!flag_ld && !clr) |=> ($stable(pwr_down) && $stable(ref_sel)));
endmodule

// File: rtl/dac_regctl.sv
module dac_regctl
  import dac_regctl_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_begin,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sync_stb,
  input  logic              sync_flag,
  output logic [DATA_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              ref_sel
);
  mode_t             in_mode;
  logic [DATA_W-1:0] in_data;
  logic              clr;
  logic              code_ld;
  logic              flag_ld;

  dac_upd_ctl u_upd (
    .clk       (clk),
    .rst       (rst),
    .in_mode   (in_mode),
    .bus_stop  (bus_stop),
    .sync_stb  (sync_stb),
    .sync_flag (sync_flag),
    .clr       (clr),
    .code_ld   (code_ld),
    .flag_ld   (flag_ld)
  );

  dac_rx_seq #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .xfer_begin (xfer_begin),
    .byte_stb   (byte_stb),
    .byte_data  (byte_data),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .in_mode    (in_mode),
    .in_data    (in_data)
  );

  dac_out_latch #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .code_ld  (code_ld),
    .flag_ld  (flag_ld),
    .in_mode  (in_mode),
    .in_data  (in_data),
    .dac_code (dac_code),
    .pwr_down (pwr_down),
    .ref_sel  (ref_sel)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !pwr_down && !ref_sel && in_mode == '0));
endmodule

// File: tb/dac_regctl_tb_top.sv
module dac_regctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xfer_begin = 1'b0, byte_stb = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
  logic       sync_stb = 1'b0, sync_flag = 1'b0;
  logic [7:0] byte_data = '0;
  logic [9:0] dac_code;
  logic       pwr_down, ref_sel;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model
  logic [7:0] m_cmd = '0;
  logic [9:0] m_data = '0;
  logic [7:0] m_stage = '0;
  int         m_st = 0;
  logic [9:0] e_code = '0;
  logic       e_pd = 1'b0, e_ref = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_regctl dut_i (
    .clk(clk), .rst(rst), .xfer_begin(xfer_begin), .byte_stb(byte_stb),
    .byte_data(byte_data), .bus_start(bus_start), .bus_stop(bus_stop),
    .sync_stb(sync_stb), .sync_flag(sync_flag),
    .dac_code(dac_code), .pwr_down(pwr_down), .ref_sel(ref_sel)
  );

  function automatic logic [9:0] join_code(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[1:0], lo};
  endfunction

  task automatic model_step();
    if (sync_stb && !sync_flag) begin
      m_cmd = '0; m_data = '0; m_stage = '0; m_st = 0;
      e_code = '0; e_pd = 1'b0; e_ref = 1'b0;
    end else begin
      if (bus_stop) begin
        e_pd = m_cmd[1]; e_ref = m_cmd[2];
        if (!m_cmd[0]) e_code = m_data;
      end
      if (sync_stb && sync_flag && m_cmd[0]) begin
        e_code = m_data; e_pd = m_cmd[1]; e_ref = m_cmd[2];
      end
      if (xfer_begin) m_st = 1;
      else if (bus_start || bus_stop) m_st = 0;
      else if (byte_stb) begin
        case (m_st)
          1: begin m_cmd = {5'b0, byte_data[2:0]}; m_st = 2; end
          2: begin m_stage = byte_data; m_st = 3; end
          3: begin m_data = join_code(byte_data, m_stage); m_st = 4; end
          default: ;
        endcase
      end
    end
  endtask

  task automatic check(input string tag);
    n_tests++;
    if (dac_code !== e_code || pwr_down !== e_pd || ref_sel !== e_ref) begin
      n_fail++;
      $display("FAIL %s: code=%h pd=%b ref=%b expected code=%h pd=%b ref=%b",
               tag, dac_code, pwr_down, ref_sel, e_code, e_pd, e_ref);
    end
  endtask

  // one cycle: inputs already set at negedge; edge; update model; compare
  task automatic step(input string tag, input bit do_chk);
    @(posedge clk);
    model_step();
    @(negedge clk);
    xfer_begin = 0; byte_stb = 0; bus_start = 0; bus_stop = 0;
    sync_stb = 0; sync_flag = 0; byte_data = '0;
    if (do_chk) check(tag);
  endtask

  task automatic ev_begin(input string tag);
    bus_start = 1; step(tag, 1);
    xfer_begin = 1; step(tag, 1);
  endtask
  task automatic ev_byte(input logic [7:0] b, input string tag);
    byte_stb = 1; byte_data = b; step(tag, 1);
  endtask
  task automatic ev_stop(input string tag);
    bus_stop = 1; step(tag, 1);
  endtask
  task automatic ev_start(input string tag);
    bus_start = 1; step(tag, 1);
  endtask
  task automatic ev_sync(input logic f, input string tag);
    sync_stb = 1; sync_flag = f; step(tag, 1);
  endtask
  task automatic word(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi, input string tag);
    ev_begin(tag); ev_byte(c, tag); ev_byte(lo, tag); ev_byte(hi, tag);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1663_5eed));
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset");

    // R2/R3/R4: upper cmd bits and upper high-byte bits ignored, update at stop
    word(8'hF8, 8'hA5, 8'hFE, "R4 before stop");
    if (dac_code !== 10'h000) begin n_fail++; $display("FAIL R4: code=%h expected 000 before stop", dac_code); end
    n_tests++;
    ev_stop("R3 code 2A5");
    if (dac_code !== 10'h2A5 || pwr_down || ref_sel) begin
      n_fail++; $display("FAIL R2: code=%h pd=%b ref=%b expected 2a5 0 0", dac_code, pwr_down, ref_sel);
    end
    n_tests++;

    word(8'h04, 8'h55, 8'h01, "R2 bg"); ev_stop("R2 bg at stop");

    // R5/R6 sync mode
    word(8'h01, 8'hFF, 8'h03, "R5 sy word"); ev_stop("R5 stop keeps code");
    ev_sync(1'b1, "R6 sync update");

    // R7, R10: send byte clears SY; sync high ignored; data kept
    ev_begin("R10 send byte"); ev_byte(8'h00, "R10 send byte"); ev_stop("R10 data kept");
    ev_sync(1'b1, "R7 sync ignored");

    // R9 power down at stop, data retained
    word(8'h02, 8'h3C, 8'h02, "R9 sd word"); ev_stop("R9 pd at stop");
    ev_begin("R9 wake"); ev_byte(8'h00, "R9 wake"); ev_stop("R9 code retained");

    // R10 interrupted write word
    ev_begin("R10 abort"); ev_byte(8'h04, "R10 abort"); ev_byte(8'h11, "R10 abort");
    ev_start("R10 abort start"); ev_stop("R10 cmd only");

    // R12 extra byte
    word(8'h00, 8'h77, 8'h01, "R12 word"); ev_byte(8'hFF, "R12 extra"); ev_byte(8'hFF, "R12 extra");
    ev_stop("R12 extra ignored");

    // R8 clear in sync mode
    word(8'h07, 8'h9A, 8'h02, "R8 word"); ev_stop("R8 pre");
    ev_sync(1'b0, "R8 clear"); ev_stop("R8 stop after clear");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      case (kind)
        0, 1, 2: word(8'($urandom), 8'($urandom), 8'($urandom), "R11 rnd word");
        3: begin ev_begin("R11 rnd send"); ev_byte(8'($urandom), "R11 rnd send"); end
        4: begin ev_begin("R10 rnd abort"); ev_byte(8'($urandom), "R10 rnd abort"); ev_byte(8'($urandom), "R10 rnd abort"); end
        5, 6: ev_stop("R11 rnd stop");
        7: ev_sync(1'b1, "R6 rnd sync");
        8: if ($urandom_range(0, 3) == 0) ev_sync(1'b0, "R8 rnd clear"); else ev_byte(8'($urandom), "R12 rnd byte");
        default: ev_start("R11 rnd start");
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule